// File: doc/BRIEF.md
# Triggered Sampling Sequence Controller

This block decides when a parallel digital input word is captured into an on-board FIFO. Three condition sources are picked on their own: one arms the capture, one paces each sample, and one ends the run. The block has four states: idle, armed (waiting for the start condition), running, and a single-cycle done state. Every captured word goes out on a FIFO write strobe with its data. A running sample count is visible at all times, and it survives the end of a run until software clears it.

Software loads the configuration while the block is idle. It then issues a start command. With the software start source, sampling begins at once. With any other start source, the block waits in the armed state until that condition occurs. The pacing source can be an internal programmable-rate tick, an external clock pin, a request/acknowledge handshake, or one of three auxiliary connector signals. The run ends on a software stop, on an edge of the external trigger pin, on an auxiliary signal, or when a programmed sample count is reached. Before each new run, a software reset command clears the count and flushes the FIFO.

Top module: `acq_seq_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls: `busy`, `done`, `fifo_we`, `fifo_flush` and `hs_ack` are low, and `sample_cnt` is 0.
- R2: The configuration is captured from the `cfg_*` inputs only when `cfg_load` is high while the block is idle. A load in any other state has no effect on the run in progress.
- R3: Start source codes on `cfg_start_src`: 0 = software (run begins on the edge that takes `sw_start`), 1 = trigger pin rising, 2 = trigger pin falling, 3 = pattern match, 4/5/6 = rising edge of `aux_in[0]`/`[1]`/`[2]`, 7 = never starts. `busy` is high in both the armed and the running state.
- R4: Pace source codes on `cfg_pace_src`: 0 = internal tick, 1 = rising edge of `ext_clk`, 2 = rising edge of `hs_req`, 3/4/5 = rising edge of `aux_in[0..2]`, 6/7 = no samples. With the internal tick, the first sample appears `cfg_rate`+1 clock edges after the run is entered, and later samples follow every `cfg_rate`+1 cycles. In handshake mode each sample comes with a one-cycle `hs_ack` pulse.
- R5: Stop source codes on `cfg_stop_src`: 0 and 7 = software only, 1 = trigger pin rising, 2 = trigger pin falling, 3/4/5 = rising edge of `aux_in[0..2]`, 6 = sample count. `sw_stop` ends an armed or running sequence under any stop code.
- R6: Each sample raises `fifo_we` for one cycle. `fifo_wdata` holds the `din` present at the clock edge where the pacing event was acted on, and `sample_cnt` goes up by one at the same edge.
- R7: With the count stop, the run ends on the edge that writes the sample bringing `sample_cnt` to `cfg_target`. If `sample_cnt` is already at or above the target, the run ends with no sample.
- R8: If a stop event and a pacing event arrive in the same cycle, the stop wins and no sample is written.
- R9: Pattern start fires on the first clock where (`din` AND `cfg_pat_mask`) equals (`cfg_pat_value` AND `cfg_pat_mask`) after being unequal. A pattern that already matches when the block is armed does not start it.
- R10: External pins pass through two synchronising flops plus an edge register. A stop pin driven before clock edge k ends the run at edge k+2, when `done` rises.
- R11: `sw_reset` while idle or done clears `sample_cnt` to 0 and pulses `fifo_flush` for one cycle. While armed or running it is ignored.
- R12: At the end of a run, `done` is high for exactly one cycle, and `busy` is low in that same cycle.
- R13: `sw_start` is ignored while the block is armed or running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Capture configuration (idle only) |
| cfg_start_src | input | 3 | Start source code |
| cfg_pace_src | input | 3 | Pace source code |
| cfg_stop_src | input | 3 | Stop source code |
| cfg_rate | input | RATE_W | Internal tick period minus one |
| cfg_target | input | CNT_W | Sample count for the count stop |
| cfg_pat_value | input | DATA_W | Pattern compare value |
| cfg_pat_mask | input | DATA_W | Pattern compare mask |
| sw_start | input | 1 | Software start command |
| sw_stop | input | 1 | Software stop command |
| sw_reset | input | 1 | Clear count and flush FIFO |
| ext_trig | input | 1 | External start/stop pin |
| aux_in | input | 3 | Auxiliary connector signals |
| ext_clk | input | 1 | External sample clock pin |
| hs_req | input | 1 | Handshake request |
| din | input | DATA_W | Input data word |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_wdata | output | DATA_W | FIFO write data |
| fifo_flush | output | 1 | FIFO flush pulse |
| hs_ack | output | 1 | Handshake acknowledge pulse |
| sample_cnt | output | CNT_W | Samples since last clear |
| busy | output | 1 | Armed or running |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench measures when the first internal-tick sample arrives and the spacing that follows. An off-by-one divider would give period `cfg_rate` or `cfg_rate`+2. It also aims a stop edge at a cycle that carries a pacing tick. A design that let the sample win would write one extra word, and a missing or extra synchroniser stage would move `done` off edge k+2. The pattern test starts with data that already matches, so a level-triggered compare would start the run too early. Other tests issue reset, start and configuration loads while the block is busy. A design that honoured them would lose the count, start sampling from the armed state, or change its rate part-way through a run.

// File: rtl/acq_pkg.sv
package acq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } acq_state_e;

  localparam int SRC_W = 3;
  localparam int AUX_N = 3;

  // start source codes
  localparam logic [SRC_W-1:0] STA_SOFT    = 3'd0;
  localparam logic [SRC_W-1:0] STA_TRIG_RE = 3'd1;
  localparam logic [SRC_W-1:0] STA_TRIG_FE = 3'd2;
  localparam logic [SRC_W-1:0] STA_PATTERN = 3'd3;
  localparam logic [SRC_W-1:0] STA_AUX0    = 3'd4;

  // pace source codes
  localparam logic [SRC_W-1:0] PAC_TICK    = 3'd0;
  localparam logic [SRC_W-1:0] PAC_ECLK    = 3'd1;
  localparam logic [SRC_W-1:0] PAC_HSHK    = 3'd2;
  localparam logic [SRC_W-1:0] PAC_AUX0    = 3'd3;

  // stop source codes
  localparam logic [SRC_W-1:0] STP_TRIG_RE = 3'd1;
  localparam logic [SRC_W-1:0] STP_TRIG_FE = 3'd2;
  localparam logic [SRC_W-1:0] STP_AUX0    = 3'd3;
  localparam logic [SRC_W-1:0] STP_COUNT   = 3'd6;

  // positions of the synchronised pins
  localparam int PIN_AUX0 = 0;
  localparam int PIN_TRIG = AUX_N;
  localparam int PIN_ECLK = AUX_N + 1;
  localparam int PIN_HSRQ = AUX_N + 2;
  localparam int PIN_N    = AUX_N + 3;

endpackage

// File: rtl/acq_edge_sync.sv
module acq_edge_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] lvl_d
);

  localparam int CHAIN = STAGES + 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [CHAIN-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[CHAIN-2:0], pin[b]};
    end
    assign lvl[b]   = chain_q[STAGES-1];
    assign lvl_d[b] = chain_q[STAGES];
  end

endmodule

// File: rtl/acq_pace_gen.sv
module acq_pace_gen #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);

  logic [RATE_W-1:0] div_q;

  assign tick = run && (div_q == rate);

  always_ff @(posedge clk) begin
    if (rst || !run) div_q <= '0;
    else if (tick)   div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

endmodule

// File: rtl/acq_cond_sel.sv
module acq_cond_sel
  import acq_pkg::*;
(
  input  logic [SRC_W-1:0] start_src,
  input  logic [SRC_W-1:0] pace_src,
  input  logic [SRC_W-1:0] stop_src,
  input  logic [PIN_N-1:0] lvl,
  input  logic [PIN_N-1:0] lvl_d,
  input  logic             int_tick,
  input  logic             pat_ev,
  output logic             start_ev,
  output logic             pace_ev,
  output logic             stop_ev
);

  logic [PIN_N-1:0] rise;
  logic             trig_fall;

  assign rise      = lvl & ~lvl_d;
  assign trig_fall = ~lvl[PIN_TRIG] & lvl_d[PIN_TRIG];

  always_comb begin
    start_ev = 1'b0;
    case (start_src)
      STA_TRIG_RE: start_ev = rise[PIN_TRIG];
      STA_TRIG_FE: start_ev = trig_fall;
      STA_PATTERN: start_ev = pat_ev;
      3'd4, 3'd5, 3'd6:
        start_ev = rise[PIN_AUX0 + int'(start_src - STA_AUX0)];
      default:     start_ev = 1'b0;
    endcase
  end

  always_comb begin
    pace_ev = 1'b0;
    case (pace_src)
      PAC_TICK: pace_ev = int_tick;
      PAC_ECLK: pace_ev = rise[PIN_ECLK];
      PAC_HSHK: pace_ev = rise[PIN_HSRQ];
      3'd3, 3'd4, 3'd5:
        pace_ev = rise[PIN_AUX0 + int'(pace_src - PAC_AUX0)];
      default:  pace_ev = 1'b0;
    endcase
  end

  always_comb begin
    stop_ev = 1'b0;
    case (stop_src)
      STP_TRIG_RE: stop_ev = rise[PIN_TRIG];
      STP_TRIG_FE: stop_ev = trig_fall;
      3'd3, 3'd4, 3'd5:
        stop_ev = rise[PIN_AUX0 + int'(stop_src - STP_AUX0)];
      default:     stop_ev = 1'b0;
    endcase
  end

endmodule

// File: rtl/acq_seq_ctrl.sv
module acq_seq_ctrl
  import acq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [2:0]        cfg_start_src,
  input  logic [2:0]        cfg_pace_src,
  input  logic [2:0]        cfg_stop_src,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic [CNT_W-1:0]  cfg_target,
  input  logic [DATA_W-1:0] cfg_pat_value,
  input  logic [DATA_W-1:0] cfg_pat_mask,
  input  logic              sw_start,
  input  logic              sw_stop,
  input  logic              sw_reset,
  input  logic              ext_trig,
  input  logic [2:0]        aux_in,
  input  logic              ext_clk,
  input  logic              hs_req,
  input  logic [DATA_W-1:0] din,
  output logic              fifo_we,
  output logic [DATA_W-1:0] fifo_wdata,
  output logic              fifo_flush,
  output logic              hs_ack,
  output logic [CNT_W-1:0]  sample_cnt,
  output logic              busy,
  output logic              done
);

  acq_state_e        state_q, state_d;

  logic [SRC_W-1:0]  start_r, pace_r, stop_r;
  logic [RATE_W-1:0] rate_r;
  logic [CNT_W-1:0]  target_r;
  logic [DATA_W-1:0] pval_r, pmask_r;

  logic [PIN_N-1:0]  pins, lvl, lvl_d;
  logic              int_tick, pat_now, pat_prev, pat_ev;
  logic              start_ev, pace_ev, stop_ev;
  logic              take, clr, cnt_mode, cnt_reached, cnt_last;

  // configuration, writable only while idle
  always_ff @(posedge clk) begin
    if (rst) begin
      start_r  <= STA_SOFT;
      pace_r   <= PAC_TICK;
      stop_r   <= '0;
      rate_r   <= '0;
      target_r <= '0;
      pval_r   <= '0;
      pmask_r  <= '0;
    end else if (cfg_load && state_q == ST_IDLE) begin
      start_r  <= cfg_start_src;
      pace_r   <= cfg_pace_src;
      stop_r   <= cfg_stop_src;
      rate_r   <= cfg_rate;
      target_r <= cfg_target;
      pval_r   <= cfg_pat_value;
      pmask_r  <= cfg_pat_mask;
    end
  end

  assign pins = {hs_req, ext_clk, ext_trig, aux_in};

  acq_edge_sync #(.WIDTH(PIN_N), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin   (pins),
    .lvl   (lvl),
    .lvl_d (lvl_d)
  );

  acq_pace_gen #(.RATE_W(RATE_W)) u_pace (
    .clk  (clk),
    .rst  (rst),
    .run  (state_q == ST_RUN),
    .rate (rate_r),
    .tick (int_tick)
  );

  // pattern compare, edge qualified
  assign pat_now = ((din & pmask_r) == (pval_r & pmask_r));
  assign pat_ev  = pat_now && !pat_prev;

  always_ff @(posedge clk) begin
    if (rst) pat_prev <= 1'b1;
    else     pat_prev <= pat_now;
  end

  acq_cond_sel u_sel (
    .start_src (start_r),
    .pace_src  (pace_r),
    .stop_src  (stop_r),
    .lvl       (lvl),
    .lvl_d     (lvl_d),
    .int_tick  (int_tick),
    .pat_ev    (pat_ev),
    .start_ev  (start_ev),
    .pace_ev   (pace_ev),
    .stop_ev   (stop_ev)
  );

  assign cnt_mode    = (stop_r == STP_COUNT);
  assign cnt_reached = cnt_mode && (sample_cnt >= target_r);
  assign cnt_last    = cnt_mode && (sample_cnt == target_r - 1'b1);
  assign clr         = sw_reset && (state_q == ST_IDLE || state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    take    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (sw_start) state_d = (start_r == STA_SOFT) ? ST_RUN : ST_ARMED;
      end
      ST_ARMED: begin
        if (sw_stop)       state_d = ST_DONE;
        else if (start_ev) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (sw_stop || stop_ev || cnt_reached) begin
          state_d = ST_DONE;
        end else if (pace_ev) begin
          take = 1'b1;
          if (cnt_last) state_d = ST_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      fifo_we    <= 1'b0;
      fifo_wdata <= '0;
      fifo_flush <= 1'b0;
      hs_ack     <= 1'b0;
      sample_cnt <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
    end else begin
      state_q    <= state_d;
      fifo_we    <= take;
      if (take) fifo_wdata <= din;
      fifo_flush <= clr;
      hs_ack     <= take && (pace_r == PAC_HSHK);
      if (clr)       sample_cnt <= '0;
      else if (take) sample_cnt <= sample_cnt + 1'b1;
      busy       <= (state_d == ST_ARMED) || (state_d == ST_RUN);
      done       <= (state_d == ST_DONE);
    end
  end

endmodule

// File: rtl/acq_seq_ctrl_chk.sv
module acq_seq_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             fifo_we,
  input logic             fifo_flush,
  input logic             hs_ack,
  input logic [CNT_W-1:0] sample_cnt,
  input logic             busy,
  input logic             done
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R12

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);  // R12

  AST_WE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (past_ok && fifo_we) |-> $past(busy));  // R6

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (past_ok && fifo_we) |-> (sample_cnt == CNT_W'($past(sample_cnt) + 1'b1)));  // R6

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !fifo_we && !fifo_flush) |-> $stable(sample_cnt));  // R11

  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    fifo_flush |-> (sample_cnt == '0 && !busy));  // R11

  AST_ACK_WITH_WE: assert property (@(posedge clk) disable iff (rst)
    hs_ack |-> fifo_we);  // R4

endmodule

bind acq_seq_ctrl acq_seq_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fifo_we    (fifo_we),
  .fifo_flush (fifo_flush),
  .hs_ack     (hs_ack),
  .sample_cnt (sample_cnt),
  .busy       (busy),
  .done       (done)
);

// File: tb/acq_seq_ctrl_tb.sv
module acq_seq_ctrl_tb;

  localparam int DW = 16;
  localparam int CW = 16;
  localparam int RW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_load = 1'b0;
  logic [2:0]    cfg_start_src = '0, cfg_pace_src = '0, cfg_stop_src = '0;
  logic [RW-1:0] cfg_rate = '0;
  logic [CW-1:0] cfg_target = '0;
  logic [DW-1:0] cfg_pat_value = '0, cfg_pat_mask = '0;
  logic          sw_start = 1'b0, sw_stop = 1'b0, sw_reset = 1'b0;
  logic          ext_trig = 1'b0, ext_clk = 1'b0, hs_req = 1'b0;
  logic [2:0]    aux_in = '0;
  logic [DW-1:0] din = '0;
  logic          fifo_we, fifo_flush, hs_ack, busy, done;
  logic [DW-1:0] fifo_wdata;
  logic [CW-1:0] sample_cnt;

  acq_seq_ctrl #(.DATA_W(DW), .CNT_W(CW), .RATE_W(RW)) u_dut (
    .clk(clk), .rst(rst), .cfg_load(cfg_load),
    .cfg_start_src(cfg_start_src), .cfg_pace_src(cfg_pace_src),
    .cfg_stop_src(cfg_stop_src), .cfg_rate(cfg_rate), .cfg_target(cfg_target),
    .cfg_pat_value(cfg_pat_value), .cfg_pat_mask(cfg_pat_mask),
    .sw_start(sw_start), .sw_stop(sw_stop), .sw_reset(sw_reset),
    .ext_trig(ext_trig), .aux_in(aux_in), .ext_clk(ext_clk), .hs_req(hs_req),
    .din(din), .fifo_we(fifo_we), .fifo_wdata(fifo_wdata),
    .fifo_flush(fifo_flush), .hs_ack(hs_ack), .sample_cnt(sample_cnt),
    .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit din_auto = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (din_auto) begin
      #2;
      din = din + 1'b1;
    end
  end

  // port monitor
  int we_seen, data_err, first_we, last_we, gap_min, gap_max;
  int ack_seen, flush_seen, done_seen, done_cyc, done_dbl;
  logic [DW-1:0] last_wdata;
  bit prev_done = 1'b0;

  task automatic clr_mon();
    we_seen = 0; data_err = 0; first_we = -1; last_we = -1;
    gap_min = 1 << 30; gap_max = -1;
    ack_seen = 0; flush_seen = 0; done_seen = 0; done_cyc = -1; done_dbl = 0;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (fifo_we) begin
        if (we_seen == 0) first_we = cyc;
        else begin
          if (cyc - last_we < gap_min) gap_min = cyc - last_we;
          if (cyc - last_we > gap_max) gap_max = cyc - last_we;
        end
        last_we = cyc;
        we_seen++;
        last_wdata = fifo_wdata;
        if (din_auto && fifo_wdata != din - 1'b1) data_err++;
      end
      if (hs_ack) ack_seen++;
      if (fifo_flush) flush_seen++;
      if (done) begin
        done_seen++;
        done_cyc = cyc;
        if (prev_done) done_dbl++;
      end
      prev_done = done;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] sa, input logic [2:0] pa,
                      input logic [2:0] so, input int rate, input int tgt);
    cfg_start_src = sa; cfg_pace_src = pa; cfg_stop_src = so;
    cfg_rate = RW'(rate); cfg_target = CW'(tgt);
    cfg_load = 1'b1;
    tick();
    cfg_load = 1'b0;
  endtask

  task automatic pulse_start();
    sw_start = 1'b1; tick(); sw_start = 1'b0;
  endtask

  task automatic pulse_stop();
    sw_stop = 1'b1; tick(); sw_stop = 1'b0;
  endtask

  task automatic pulse_reset();
    sw_reset = 1'b1; tick(); sw_reset = 1'b0;
  endtask

  task automatic wait_done(input int lim, input string req);
    int n = 0;
    while (done_seen == 0 && n < lim) begin tick(); n++; end
    chk(done_seen == 1, req, "run ended with one done", done_seen, 1);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !fifo_we && !fifo_flush && !hs_ack, "R1",
        "control outputs low", {busy, done, fifo_we, fifo_flush, hs_ack}, 0);
    chk(sample_cnt == 0, "R1", "count after reset", int'(sample_cnt), 0);
  endtask

  task automatic t_tick_count();
    int s;
    clr_mon();
    din_auto = 1'b1;
    load(3'd0, 3'd0, 3'd6, 3, 5);
    s = cyc;
    pulse_start();
    wait_done(200, "R7");
    tick();
    chk(we_seen == 5, "R7", "samples before count stop", we_seen, 5);
    chk(first_we - s == 5, "R4", "first tick latency", first_we - s, 5);
    chk(gap_min == 4 && gap_max == 4, "R4", "tick spacing", gap_max, 4);
    chk(data_err == 0, "R6", "write data mismatches", data_err, 0);
    chk(sample_cnt == 5, "R12", "count kept after done", int'(sample_cnt), 5);
    chk(done_dbl == 0 && !busy, "R12", "done width / busy", done_dbl, 0);
    din_auto = 1'b0;
  endtask

  task automatic t_busy_ignores();
    clr_mon();
    load(3'd7, 3'd0, 3'd0, 0, 0);
    pulse_start();
    ticks(2);
    chk(busy == 1'b1, "R3", "armed with never-start code", busy, 1);
    pulse_start();
    ticks(4);
    chk(we_seen == 0, "R13", "no samples after start while armed", we_seen, 0);
    pulse_reset();
    ticks(2);
    chk(flush_seen == 0 && sample_cnt == 5, "R11", "reset ignored while busy",
        int'(sample_cnt), 5);
    pulse_stop();
    ticks(2);
    chk(done_seen == 1 && !busy, "R5", "software stop from armed", done_seen, 1);
  endtask

  task automatic t_reset_and_zero();
    clr_mon();
    pulse_reset();
    tick();
    chk(flush_seen == 1 && sample_cnt == 0, "R11", "reset clears and flushes",
        int'(sample_cnt), 0);
    load(3'd0, 3'd0, 3'd6, 0, 0);
    pulse_start();
    wait_done(20, "R7");
    chk(we_seen == 0, "R7", "zero target writes nothing", we_seen, 0);
  endtask

  task automatic t_cfg_locked();
    clr_mon();
    pulse_reset();
    din_auto = 1'b1;
    load(3'd0, 3'd0, 3'd6, 1, 6);
    pulse_start();
    load(3'd0, 3'd0, 3'd6, 5, 2);
    wait_done(200, "R2");
    chk(we_seen == 6, "R2", "target unchanged by busy load", we_seen, 6);
    chk(gap_min == 2 && gap_max == 2, "R2", "rate unchanged by busy load",
        gap_max, 2);
    din_auto = 1'b0;
  endtask

  task automatic t_ext_pins();
    clr_mon();
    pulse_reset();
    load(3'd1, 3'd1, 3'd2, 0, 0);
    pulse_start();
    for (int i = 0; i < 2; i++) begin
      ext_clk = 1'b1; ticks(4); ext_clk = 1'b0; ticks(4);
    end
    chk(we_seen == 0 && busy, "R3", "no samples while armed", we_seen, 0);
    ext_trig = 1'b1; ticks(5);
    for (int i = 0; i < 3; i++) begin
      ext_clk = 1'b1; ticks(4); ext_clk = 1'b0; ticks(4);
    end
    chk(we_seen == 3, "R4", "one sample per ext clock edge", we_seen, 3);
    ext_trig = 1'b0;
    wait_done(20, "R5");
    chk(sample_cnt == 3, "R5", "count at trigger-fall stop", int'(sample_cnt), 3);
  endtask

  task automatic t_handshake_aux();
    clr_mon();
    pulse_reset();
    load(3'd5, 3'd2, 3'd5, 0, 0);
    pulse_start();
    aux_in[1] = 1'b1; ticks(4); aux_in[1] = 1'b0; ticks(2);
    for (int i = 0; i < 4; i++) begin
      hs_req = 1'b1; ticks(4); hs_req = 1'b0; ticks(4);
    end
    chk(we_seen == 4, "R4", "handshake samples", we_seen, 4);
    chk(ack_seen == 4, "R4", "handshake acknowledges", ack_seen, 4);
    aux_in[2] = 1'b1; ticks(4); aux_in[2] = 1'b0;
    wait_done(20, "R5");
  endtask

  task automatic t_pattern();
    clr_mon();
    pulse_reset();
    cfg_pat_value = 16'h00A0; cfg_pat_mask = 16'h00F0;
    din = 16'h00A5;
    load(3'd3, 3'd0, 3'd6, 0, 3);
    pulse_start();
    ticks(5);
    chk(we_seen == 0 && busy, "R9", "held match does not start", we_seen, 0);
    din = 16'h0011; ticks(2);
    din = 16'h00A7;
    wait_done(20, "R9");
    chk(we_seen == 3, "R9", "samples after pattern start", we_seen, 3);
    chk(last_wdata == 16'h00A7, "R6", "captured word", int'(last_wdata), 16'h00A7);
  endtask

  task automatic t_stop_priority();
    int s, a;
    clr_mon();
    pulse_reset();
    load(3'd0, 3'd0, 3'd3, 0, 0);
    s = cyc;
    pulse_start();
    ticks(6);
    a = cyc;
    aux_in[0] = 1'b1;
    wait_done(20, "R8");
    aux_in[0] = 1'b0;
    chk(we_seen == a + 1 - s, "R8", "stop beats same-cycle sample", we_seen,
        a + 1 - s);
    chk(done_cyc == a + 3, "R10", "stop latency through sync", done_cyc - a, 3);
    ticks(2);
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin @(posedge clk); wd++; end
    fails++; checks++;
    $display("FAIL watchdog: actual %0d expected below %0d", wd, 100000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    clr_mon();
    ticks(3);
    t_reset();
    rst = 1'b0;
    tick();
    t_reset();
    t_tick_count();
    t_busy_ignores();
    t_reset_and_zero();
    t_cfg_locked();
    t_ext_pins();
    t_handshake_aux();
    t_pattern();
    t_stop_priority();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule